// File: doc/BRIEF.md
# Multi-Mode Timer Counter with Clock-Enable Prescaler

This block is a timer counter whose length can be chosen at run time: 8, 10, 12 or 16 bits. Four clock-enable inputs come into the block, and a source select field picks one of them. The picked enable goes through a prescaler that passes every enable, or every second, fourth or eighth enable. Each prescaler output advances the counter by one step. The step follows one of four count modes: halted, counting up to a compare value, free running over the whole length, or counting up to the compare value and back down to zero.

The block has three registered outputs. The first is the counter value. The second is a one-cycle pulse when a step lands on the compare value. The third is a sticky rollover flag that is set each time the count returns to zero through a wrap or the end of a down slope. A compare value above the largest count of the chosen length changes how the up and up/down modes run: both modes then wrap at the length maximum. A clear strobe returns the counter, the count direction, the prescaler and the flag to their initial state. Apart from this strobe, only the synchronous power-on reset touches the prescaler state.

Top module: `mode_timer`

## Requirements
- R1: While `rst` is high, and in the cycle after `clr` is high, `count` is 0, `eq_hit` is 0 and `roll_irq` is 0. The prescaler phase is also zeroed. After a clear, the first division period begins fresh.
- R2: With `mode` = 2'b00 (halt), `count` does not change on any enable.
- R3: With `mode` = 2'b01 (up) and `cmp0` not above the length maximum, each step adds 1 until `count` equals `cmp0`. The next step gives 0.
- R4: In up mode with `cmp0` above the length maximum, the counter wraps from the length maximum to 0.
- R5: With `mode` = 2'b10 (free running), the counter wraps from the length maximum to 0. `len_sel` encodes 2'b00 = 16 bits (0xFFFF), 2'b01 = 12 bits (0x0FFF), 2'b10 = 10 bits (0x03FF) and 2'b11 = 8 bits (0x00FF).
- R6: With `mode` = 2'b11 (up/down), the counter rises to `cmp0`, then falls to 0, then rises again. The period is 2*`cmp0` steps.
- R7: In up/down mode with `cmp0` above the length maximum, the counter behaves as in free-running mode. It goes from the maximum to 0 and never counts down.
- R8: `div_sel` 2'b00, 2'b01, 2'b10 and 2'b11 give one step per 1, 2, 4 and 8 selected enables. The step falls on the last enable of each group.
- R9: `src_tick[src_sel]` is the only enable that reaches the prescaler. The other bits of `src_tick` have no effect.
- R10: Changing `mode`, `len_sel`, `cmp0` or `div_sel` leaves the prescaler phase unchanged. The prescaler counts selected enables in every mode.
- R11: `roll_irq` is set when a step wraps the count to 0 in up or free-running mode, and when a down step reaches 0 in up/down mode. It stays set until `clr` or `rst`.
- R12: `eq_hit` is high for the single cycle after a step whose new count equals `cmp0` (mode not halted). It is low in the cycle after a clock with no step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| clr | input | 1 | Clear strobe: counter, direction, prescaler and flag |
| src_tick | input | NSRC (4) | Clock-enable sources, one per index |
| src_sel | input | SELW (2) | Index of the enable that feeds the prescaler |
| div_sel | input | DIVW (2) | Prescaler ratio select |
| mode | input | 2 | Count mode: 00 halt, 01 up, 10 free run, 11 up/down |
| len_sel | input | 2 | Counter length select |
| cmp0 | input | CW (16) | Compare-0 value |
| count | output | CW (16) | Current counter value |
| eq_hit | output | 1 | One-cycle pulse when a step lands on `cmp0` |
| roll_irq | output | 1 | Sticky rollover / zero-reached flag |

## Verification
The hardest situation to reach from the ports is a prescaler phase carried partway through a division group across a settings change. The phase cannot be seen, so it has to be inferred from the step on which the counter first moves. The stimulus issues three enables at divide-by-8, changes length, compare value and mode, and then shows that the fifth further enable gives the first step. A second run places a clear strobe in the middle of a group and shows that eight more enables are then needed. Compare values above the length maximum in up and up/down modes need long enable runs past the 8-bit boundary. The vector table holds such runs, so both the missing turnaround and the wrap can be seen.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

  typedef enum logic [1:0] {
    MODE_HALT = 2'b00,
    MODE_UP   = 2'b01,
    MODE_FREE = 2'b10,
    MODE_UPDN = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    LEN_16 = 2'b00,
    LEN_12 = 2'b01,
    LEN_10 = 2'b10,
    LEN_8  = 2'b11
  } len_e;

  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } dir_e;

  // Number of counter bits for each length code
  function automatic int len_bits(len_e l);
    case (l)
      LEN_16:  return 16;
      LEN_12:  return 12;
      LEN_10:  return 10;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int NSRC = 4,
  parameter int SELW = $clog2(NSRC),
  parameter int DIVW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [NSRC-1:0] src_tick,
  input  logic [SELW-1:0] src_sel,
  input  logic [DIVW-1:0] div_sel,
  output logic            step
);
  // phase counter wide enough for the largest ratio 2**(2**DIVW - 1)
  localparam int PCW = (1 << DIVW) - 1;

  logic           sel_tick;
  logic [PCW-1:0] phase_q;
  logic [PCW-1:0] mask;

  assign sel_tick = src_tick[src_sel];

  always_comb begin
    mask = '0;
    for (int b = 0; b < PCW; b++) begin
      if (b < int'(div_sel)) mask[b] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase_q <= '0;
    end else if (sel_tick) begin
      phase_q <= phase_q + PCW'(1);
    end
  end

  assign step = sel_tick && ((phase_q & mask) == mask);

  // R10: phase moves only on a selected enable, whatever the settings do
  assert_phase_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!clr && !sel_tick) |=> $stable(phase_q));

  // R1: clear strobe zeroes the prescaler phase
  assert_phase_clear_R1: assert property (@(posedge clk) disable iff (rst)
    clr |=> (phase_q == '0));

endmodule

// File: rtl/limit_dec.sv
module limit_dec
  import mtimer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [1:0]    len_sel,
  input  logic [CW-1:0] cmp0,
  output logic [CW-1:0] lmax,
  output logic          cmp_big
);
  always_comb begin
    lmax = '0;
    for (int b = 0; b < CW; b++) begin
      if (b < len_bits(len_e'(len_sel))) lmax[b] = 1'b1;
    end
  end

  assign cmp_big = (cmp0 > lmax);

endmodule

// File: rtl/count_ctl.sv
module count_ctl
  import mtimer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] cmp0,
  input  logic [CW-1:0] lmax,
  input  logic          cmp_big,
  output logic [CW-1:0] count,
  output logic          eq_hit,
  output logic          zero_evt
);
  localparam logic [CW-1:0] ONE = CW'(1);

  cnt_mode_e     md;
  dir_e          dir_q, dir_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          hit_n;
  logic [CW-1:0] up_lim;

  assign md     = cnt_mode_e'(mode);
  assign up_lim = cmp_big ? lmax : cmp0;

  always_comb begin
    cnt_n = cnt_q;
    dir_n = dir_q;
    hit_n = 1'b0;
    if (step) begin
      case (md)
        MODE_HALT: ;
        MODE_UP: begin
          dir_n = DIR_UP;
          if (cnt_q >= up_lim) begin
            cnt_n = '0;
            hit_n = 1'b1;
          end else begin
            cnt_n = cnt_q + ONE;
          end
        end
        MODE_FREE: begin
          dir_n = DIR_UP;
          if (cnt_q >= lmax) begin
            cnt_n = '0;
            hit_n = 1'b1;
          end else begin
            cnt_n = cnt_q + ONE;
          end
        end
        default: begin // up/down
          if (cmp_big) begin
            dir_n = DIR_UP;
            if (cnt_q >= lmax) begin
              cnt_n = '0;
              hit_n = 1'b1;
            end else begin
              cnt_n = cnt_q + ONE;
            end
          end else if (dir_q == DIR_UP && cnt_q < cmp0) begin
            cnt_n = cnt_q + ONE;
          end else if (dir_q == DIR_UP && cnt_q == '0) begin
            cnt_n = '0;        // compare value zero: stay at zero
          end else if (cnt_q <= ONE) begin
            cnt_n = '0;        // down slope reaches zero
            dir_n = DIR_UP;
            hit_n = 1'b1;
          end else begin
            cnt_n = cnt_q - ONE;
            dir_n = DIR_DN;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q  <= '0;
      dir_q  <= DIR_UP;
      eq_hit <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      dir_q  <= dir_n;
      eq_hit <= step && (md != MODE_HALT) && (cnt_n == cmp0);
    end
  end

  assign count    = cnt_q;
  assign zero_evt = hit_n;

  // R2: halted counter keeps its value
  assert_halt_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (md == MODE_HALT && !clr) |=> $stable(cnt_q));

  // R1: clear strobe empties counter and compare pulse
  assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0 && !eq_hit));

  // R5: free-running count never exceeds the length maximum after a step
  assert_range_R5: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && md == MODE_FREE) |=> (cnt_q <= $past(lmax)));

  // R7: oversize compare in up/down mode never turns the count downward
  assert_no_turn_R7: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && md == MODE_UPDN && cmp_big && cnt_q < lmax)
      |=> (cnt_q == $past(cnt_q) + ONE));

  // R12: compare pulse only follows a step landing on the compare value
  assert_eq_src_R12: assert property (@(posedge clk) disable iff (rst)
    eq_hit |-> ($past(step) && cnt_q == $past(cmp0)));

endmodule

// File: rtl/mode_timer.sv
module mode_timer
  import mtimer_pkg::*;
#(
  parameter int CW   = 16,
  parameter int NSRC = 4,
  parameter int SELW = $clog2(NSRC),
  parameter int DIVW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [NSRC-1:0] src_tick,
  input  logic [SELW-1:0] src_sel,
  input  logic [DIVW-1:0] div_sel,
  input  logic [1:0]      mode,
  input  logic [1:0]      len_sel,
  input  logic [CW-1:0]   cmp0,
  output logic [CW-1:0]   count,
  output logic            eq_hit,
  output logic            roll_irq
);
  logic          step;
  logic [CW-1:0] lmax;
  logic          cmp_big;
  logic          zero_evt;

  tick_gen #(.NSRC(NSRC), .SELW(SELW), .DIVW(DIVW)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .src_tick (src_tick),
    .src_sel  (src_sel),
    .div_sel  (div_sel),
    .step     (step)
  );

  limit_dec #(.CW(CW)) u_lim (
    .len_sel (len_sel),
    .cmp0    (cmp0),
    .lmax    (lmax),
    .cmp_big (cmp_big)
  );

  count_ctl #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .step     (step),
    .mode     (mode),
    .cmp0     (cmp0),
    .lmax     (lmax),
    .cmp_big  (cmp_big),
    .count    (count),
    .eq_hit   (eq_hit),
    .zero_evt (zero_evt)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      roll_irq <= 1'b0;
    end else if (zero_evt) begin
      roll_irq <= 1'b1;
    end
  end

  // R11: flag is sticky until cleared
  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (roll_irq && !clr) |=> roll_irq);

  // R1: clear strobe drops the flag
  assert_flag_clear_R1: assert property (@(posedge clk) disable iff (rst)
    clr |=> !roll_irq);

  // R11: flag rises only after the count reached zero
  assert_flag_zero_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(roll_irq) |-> (count == '0));

endmodule

// File: tb/mode_timer_test.sv
module mode_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic [3:0]  src_tick = '0;
  logic [1:0]  src_sel = '0;
  logic [1:0]  div_sel = '0;
  logic [1:0]  mode = '0;
  logic [1:0]  len_sel = '0;
  logic [15:0] cmp0 = '0;
  logic [15:0] count;
  logic        eq_hit;
  logic        roll_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mode_timer uut (
    .clk(clk), .rst(rst), .clr(clr), .src_tick(src_tick), .src_sel(src_sel),
    .div_sel(div_sel), .mode(mode), .len_sel(len_sel), .cmp0(cmp0),
    .count(count), .eq_hit(eq_hit), .roll_irq(roll_irq)
  );

  typedef struct packed {
    logic [1:0]  md;
    logic [1:0]  ln;
    logic [1:0]  dv;
    logic [1:0]  sr;
    logic [15:0] cp;
    logic [15:0] n;
    logic [15:0] ex;
    logic        fl;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 2'd0, 2'd0, 2'd0, 16'd5,     16'd5,    16'd5,    1'b0, 4'd3},  // R3
    '{2'd1, 2'd0, 2'd0, 2'd1, 16'd5,     16'd6,    16'd0,    1'b1, 4'd3},  // R3
    '{2'd1, 2'd0, 2'd0, 2'd2, 16'd5,     16'd8,    16'd2,    1'b1, 4'd3},  // R3
    '{2'd1, 2'd3, 2'd0, 2'd3, 16'h01F0,  16'd255,  16'h00FF, 1'b0, 4'd4},  // R4
    '{2'd1, 2'd3, 2'd0, 2'd0, 16'h01F0,  16'd256,  16'd0,    1'b1, 4'd4},  // R4
    '{2'd2, 2'd3, 2'd0, 2'd1, 16'd0,     16'd300,  16'd44,   1'b1, 4'd5},  // R5
    '{2'd2, 2'd2, 2'd0, 2'd2, 16'd0,     16'd1030, 16'd6,    1'b1, 4'd5},  // R5
    '{2'd2, 2'd1, 2'd0, 2'd3, 16'd0,     16'd4100, 16'd4,    1'b1, 4'd5},  // R5
    '{2'd2, 2'd0, 2'd0, 2'd0, 16'd0,     16'd10,   16'd10,   1'b0, 4'd5},  // R5
    '{2'd3, 2'd0, 2'd0, 2'd1, 16'd3,     16'd3,    16'd3,    1'b0, 4'd6},  // R6
    '{2'd3, 2'd0, 2'd0, 2'd2, 16'd3,     16'd5,    16'd1,    1'b0, 4'd6},  // R6
    '{2'd3, 2'd0, 2'd0, 2'd3, 16'd3,     16'd6,    16'd0,    1'b1, 4'd6},  // R6
    '{2'd3, 2'd0, 2'd0, 2'd0, 16'd3,     16'd7,    16'd1,    1'b1, 4'd6},  // R6
    '{2'd3, 2'd3, 2'd0, 2'd1, 16'h0300,  16'd255,  16'h00FF, 1'b0, 4'd7},  // R7
    '{2'd3, 2'd3, 2'd0, 2'd2, 16'h0300,  16'd258,  16'd2,    1'b1, 4'd7},  // R7
    '{2'd1, 2'd0, 2'd1, 2'd3, 16'd100,   16'd10,   16'd5,    1'b0, 4'd8},  // R8
    '{2'd1, 2'd0, 2'd2, 2'd0, 16'd100,   16'd10,   16'd2,    1'b0, 4'd8},  // R8
    '{2'd1, 2'd0, 2'd3, 2'd1, 16'd100,   16'd17,   16'd2,    1'b0, 4'd8},  // R8
    '{2'd0, 2'd0, 2'd0, 2'd2, 16'd5,     16'd10,   16'd0,    1'b0, 4'd2}   // R2
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic ticks(int n, int idx);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) src_tick[idx] = 1'b1;
      @(negedge clk) src_tick = '0;
    end
  endtask

  task automatic cfg(logic [1:0] m, logic [1:0] l, logic [1:0] d,
                     logic [1:0] s, logic [15:0] c);
    mode = m; len_sel = l; div_sel = d; src_sel = s; cmp0 = c;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset count", 32'(count), 0);
    chk("R1 reset eq_hit", 32'(eq_hit), 0);
    chk("R1 reset roll_irq", 32'(roll_irq), 0);
    @(negedge clk) rst = 1'b0;

    // table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk) cfg(VECS[v].md, VECS[v].ln, VECS[v].dv, VECS[v].sr, VECS[v].cp);
      pulse_clr();
      ticks(int'(VECS[v].n), int'(VECS[v].sr));
      chk($sformatf("R%0d vec %0d count", VECS[v].rq, v), 32'(count), 32'(VECS[v].ex));
      chk($sformatf("R%0d vec %0d roll_irq", VECS[v].rq, v), 32'(roll_irq), 32'(VECS[v].fl));
    end

    // R9: unselected enables are ignored
    @(negedge clk) cfg(2'd1, 2'd0, 2'd0, 2'd2, 16'd50);
    pulse_clr();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk) src_tick = 4'b1011;
      @(negedge clk) src_tick = '0;
    end
    chk("R9 other sources ignored", 32'(count), 0);
    ticks(1, 2);
    chk("R9 selected source steps", 32'(count), 1);

    // R12: compare pulse lasts one cycle
    @(negedge clk) cfg(2'd1, 2'd0, 2'd0, 2'd0, 16'd4);
    pulse_clr();
    ticks(3, 0);
    chk("R12 no pulse before compare", 32'(eq_hit), 0);
    ticks(1, 0);
    chk("R12 pulse at compare", 32'(eq_hit), 1);
    @(negedge clk);
    chk("R12 pulse drops", 32'(eq_hit), 0);

    // R10: prescaler phase kept across settings changes
    @(negedge clk) cfg(2'd1, 2'd0, 2'd3, 2'd0, 16'd100);
    pulse_clr();
    ticks(3, 0);
    @(negedge clk) cfg(2'd2, 2'd3, 2'd3, 2'd0, 16'd90);
    ticks(4, 0);
    chk("R10 no step before group end", 32'(count), 0);
    ticks(1, 0);
    chk("R10 phase kept", 32'(count), 1);

    // R1: clear restarts the prescaler group
    ticks(3, 0);
    pulse_clr();
    ticks(7, 0);
    chk("R1 clear restarts prescaler", 32'(count), 0);
    ticks(1, 0);
    chk("R1 first step after clear", 32'(count), 1);

    // R11 / R2: sticky flag, halt holds
    @(negedge clk) cfg(2'd1, 2'd0, 2'd0, 2'd1, 16'd2);
    pulse_clr();
    ticks(3, 1);
    chk("R11 flag set on wrap", 32'(roll_irq), 1);
    @(negedge clk) mode = 2'd0;
    ticks(5, 1);
    chk("R11 flag sticky", 32'(roll_irq), 1);
    chk("R2 halt holds count", 32'(count), 0);
    pulse_clr();
    chk("R11 flag cleared", 32'(roll_irq), 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule